// File: doc/BRIEF.md
# CAN Transmit Buffer Handshake Controller

This block arbitrates ownership of one outgoing message buffer between a host processor and a CAN protocol engine. The host loads an identifier byte, a control byte and up to eight data bytes into the buffer, then raises a send request. From that moment the buffer is locked: the engine owns it, and any host write is discarded without a trace. The engine signals when the frame goes onto the bus, when it finishes without error, and when arbitration is lost. A lost frame goes back into the queue and is retried with no host action.

The host sees two registered status flags. `sts_free` shows whether it may write the buffer. `sts_done` shows whether the most recent requested frame went out successfully. A cancel command takes effect only while the frame is still queued. It hands the buffer back without claiming success. Once the frame is on the bus, a cancel is ignored. The engine reads buffer bytes through a read port with one cycle of latency, so the storage can map onto block RAM.

Top module: `can_txbuf_ctrl`

## Requirements
- R1: After a synchronous reset, `sts_free`=1, `sts_done`=1 and `eng_pending`=0, meaning the buffer is idle.
- R2: A `host_req` pulse while idle sets `sts_done`=0, `sts_free`=0 and `eng_pending`=1 one cycle later.
- R3: An `eng_start` pulse while queued sets `eng_pending`=0 and keeps `sts_free`=0 and `sts_done`=0. If `eng_start` and `host_abort` arrive in the same cycle, `eng_start` wins.
- R4: An `eng_done` pulse while on the bus sets both `sts_free`=1 and `sts_done`=1 in the same cycle, one cycle after the pulse.
- R5: A `host_abort` pulse while queued returns the buffer to idle. `sts_free` becomes 1, `eng_pending` becomes 0 and `sts_done` stays 0.
- R6: A `host_abort` pulse while the frame is on the bus has no effect. A later `eng_done` still completes the frame normally.
- R7: An `eng_lost` pulse while on the bus requeues the frame. `eng_pending` becomes 1, and `sts_done` and `sts_free` stay 0.
- R8: A `host_req` pulse while the buffer is locked is ignored. After the frame completes, the block is idle and not queued again.
- R9: Host writes are stored only while `sts_free`=1. Writes while locked leave the stored byte unchanged. The engine read port returns the byte one cycle after the address is presented.
- R10: After an abort, `sts_done` returns to 1 only once a new request has been made and that frame has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host send request pulse |
| host_abort | input | 1 | Host cancel pulse |
| host_wr_en | input | 1 | Host buffer write strobe |
| host_wr_addr | input | ADDR_W (4) | Host byte address, 0..DEPTH-1 |
| host_wr_data | input | 8 | Host write byte |
| eng_start | input | 1 | Engine: frame began on the bus |
| eng_done | input | 1 | Engine: frame sent successfully |
| eng_lost | input | 1 | Engine: arbitration lost |
| eng_rd_addr | input | ADDR_W (4) | Engine read address |
| eng_rd_data | output | 8 | Engine read byte, one cycle latency |
| eng_pending | output | 1 | Frame queued and waiting for the bus |
| sts_free | output | 1 | Buffer writable by the host |
| sts_done | output | 1 | Last requested frame completed |

## Verification
Every status flag is a register that is updated from the next state. A host or engine pulse applied before a rising edge therefore shows on the flags right after that edge, one cycle later. The engine read data also appears one edge after its address. The bench drives each pulse on a falling edge, holds it across exactly one rising edge, and samples on the following falling edge. Each flag is compared there, so no check depends on the order of events at the active edge.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PEND = 2'd1,
    TX_ACT  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/txb_fsm.sv
module txb_fsm
  import txb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic abort,
  input  logic start,
  input  logic done,
  input  logic lost,
  output logic free_q,
  output logic done_q,
  output logic pend_q
);
  tx_state_t st, st_n;

  always_comb begin
    st_n = st;
    case (st)
      TX_IDLE: if (req) st_n = TX_PEND;
      TX_PEND: begin
        if (start)      st_n = TX_ACT;   // start outranks a late abort
        else if (abort) st_n = TX_IDLE;
      end
      TX_ACT: begin
        if (done)      st_n = TX_IDLE;
        else if (lost) st_n = TX_PEND;   // retry automatically
      end
      default: st_n = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TX_IDLE;
      free_q <= 1'b1;
      done_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      st     <= st_n;
      free_q <= (st_n == TX_IDLE);
      pend_q <= (st_n == TX_PEND);
      if (st == TX_IDLE && req)      done_q <= 1'b0;
      else if (st == TX_ACT && done) done_q <= 1'b1;
    end
  end

  // R2: request from idle locks buffer and clears completion
  p_req_locks_r2: assert property (@(posedge clk) disable iff (rst)
    (st == TX_IDLE && req) |=> (!free_q && !done_q && pend_q));

  // R4: completion releases and flags success together
  p_done_release_r4: assert property (@(posedge clk) disable iff (rst)
    (st == TX_ACT && done) |=> (free_q && done_q));

  // R6: abort on the bus is ignored
  p_abort_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (st == TX_ACT && abort && !done && !lost) |=> (st == TX_ACT && !free_q));

  // R7: lost arbitration requeues without completion
  p_lost_retry_r7: assert property (@(posedge clk) disable iff (rst)
    (st == TX_ACT && lost && !done) |=> (pend_q && !done_q && !free_q));

  // R5: abort while queued releases with completion still clear
  p_abort_pend_r5: assert property (@(posedge clk) disable iff (rst)
    (st == TX_PEND && abort && !start) |=> (free_q && !done_q && !pend_q));

  // R3: flags never claim both free and queued
  p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({free_q, pend_q}));
endmodule

// File: rtl/txb_store.sv
module txb_store #(
  parameter int DEPTH  = 10,
  parameter int DATA_W = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_allow,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_ok;

  assign wr_ok = wr_en && wr_allow && (int'(wr_addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (int'(rd_addr) < DEPTH) rd_data <= mem[rd_addr];
    else                       rd_data <= '0;
  end

  // R9: a write while locked leaves the addressed byte unchanged
  p_locked_drop_r9: assert property (@(posedge clk)
    (wr_en && !wr_allow && (int'(wr_addr) < DEPTH)) |=>
      (mem[$past(wr_addr)] == $past(mem[wr_addr])));
endmodule

// File: rtl/can_txbuf_ctrl.sv
module can_txbuf_ctrl #(
  parameter int DEPTH  = 10,
  parameter int DATA_W = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_abort,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              eng_start,
  input  logic              eng_done,
  input  logic              eng_lost,
  input  logic [ADDR_W-1:0] eng_rd_addr,
  output logic [DATA_W-1:0] eng_rd_data,
  output logic              eng_pending,
  output logic              sts_free,
  output logic              sts_done
);
  txb_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .req    (host_req),
    .abort  (host_abort),
    .start  (eng_start),
    .done   (eng_done),
    .lost   (eng_lost),
    .free_q (sts_free),
    .done_q (sts_done),
    .pend_q (eng_pending)
  );

  txb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .wr_allow (sts_free),
    .wr_en    (host_wr_en),
    .wr_addr  (host_wr_addr),
    .wr_data  (host_wr_data),
    .rd_addr  (eng_rd_addr),
    .rd_data  (eng_rd_data)
  );

  // R1: state right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (sts_free && sts_done && !eng_pending));
endmodule

// File: tb/sim_can_txbuf_ctrl.sv
`timescale 1ns/1ps
module sim_can_txbuf_ctrl;
  localparam int AW = 4;
  logic clk = 1'b0;
  logic rst, req, abrt, wen, st, dn, ls;
  logic [AW-1:0] waddr, raddr;
  logic [7:0] wdata, rdata;
  logic pend, free, done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  can_txbuf_ctrl u0 (
    .clk(clk), .rst(rst), .host_req(req), .host_abort(abrt),
    .host_wr_en(wen), .host_wr_addr(waddr), .host_wr_data(wdata),
    .eng_start(st), .eng_done(dn), .eng_lost(ls),
    .eng_rd_addr(raddr), .eng_rd_data(rdata), .eng_pending(pend),
    .sts_free(free), .sts_done(done)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic flags(input string tag, input int f, input int d, input int p);
    check({tag, " free"}, free, f);
    check({tag, " done"}, done, d);
    check({tag, " pending"}, pend, p);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: req = 1; 1: abrt = 1; 2: st = 1; 3: dn = 1; 4: ls = 1;
      default: ;
    endcase
    @(negedge clk);
    req = 0; abrt = 0; st = 0; dn = 0; ls = 0;
  endtask

  task automatic write(input int a, input int d);
    @(negedge clk);
    wen = 1; waddr = AW'(a); wdata = 8'(d);
    @(negedge clk);
    wen = 0;
  endtask

  task automatic readb(input int a, output int d);
    @(negedge clk);
    raddr = AW'(a);
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    flags("R1 reset", 1, 1, 0);
  endtask

  task automatic t_send_ok;
    pulse(0); flags("R2 request", 0, 0, 1);
    pulse(2); flags("R3 start", 0, 0, 0);
    pulse(3); flags("R4 complete", 1, 1, 0);
  endtask

  task automatic t_start_beats_abort;
    pulse(0);
    @(negedge clk); st = 1; abrt = 1;
    @(negedge clk); st = 0; abrt = 0;
    flags("R3 start over abort", 0, 0, 0);
    pulse(3); flags("R3 then complete", 1, 1, 0);
  endtask

  task automatic t_abort_pending;
    pulse(0);
    pulse(1); flags("R5 abort queued", 1, 0, 0);
    repeat (3) @(negedge clk);
    flags("R10 stays clear", 1, 0, 0);
    pulse(0); flags("R10 new request", 0, 0, 1);
    pulse(2); pulse(3); flags("R10 complete", 1, 1, 0);
  endtask

  task automatic t_abort_active;
    pulse(0); pulse(2);
    pulse(1); flags("R6 abort on bus", 0, 0, 0);
    pulse(3); flags("R6 completes", 1, 1, 0);
  endtask

  task automatic t_lost_retry;
    pulse(0); pulse(2);
    pulse(4); flags("R7 lost", 0, 0, 1);
    pulse(2); pulse(3); flags("R7 retry done", 1, 1, 0);
  endtask

  task automatic t_req_locked;
    pulse(0);
    pulse(0); flags("R8 req queued", 0, 0, 1);
    pulse(2);
    pulse(0); flags("R8 req active", 0, 0, 0);
    pulse(3); flags("R8 idle after", 1, 1, 0);
    repeat (2) @(negedge clk);
    flags("R8 not requeued", 1, 1, 0);
  endtask

  task automatic t_write_gate;
    int v;
    write(2, 8'hA5); write(9, 8'h5C);
    readb(2, v); check("R9 stored byte", v, 8'hA5);
    readb(9, v); check("R9 last byte", v, 8'h5C);
    pulse(0);
    write(2, 8'h3C);
    readb(2, v); check("R9 locked queued", v, 8'hA5);
    pulse(2);
    write(9, 8'h11);
    readb(9, v); check("R9 locked active", v, 8'h5C);
    pulse(3);
    write(2, 8'h77);
    readb(2, v); check("R9 free again", v, 8'h77);
  endtask

  initial begin
    rst = 0; req = 0; abrt = 0; wen = 0; st = 0; dn = 0; ls = 0;
    waddr = '0; raddr = '0; wdata = '0;
    t_reset();
    t_send_ok();
    t_start_beats_abort();
    t_abort_pending();
    t_abort_active();
    t_lost_retry();
    t_req_locked();
    t_write_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule